// File: doc/BRIEF.md
# Serial Bus Port with Attention Acknowledge

This block sits between the parallel I/O port of a disk-drive controller and a three-wire open-collector serial bus. The bus has an attention line, a clock line and a data line. Each line is active low and pulled up, so a device can only pull a line down or let it go. The block samples the raw lines through a synchronizer and builds the byte that the controller CPU reads from the port. It also turns the port output and direction registers into pull-down enables for the clock and data lines.

A hardware acknowledge path pulls the data line low with no firmware help. It does so whenever the state of the attention line differs from a software acknowledge enable. The bus master therefore sees a response to attention as soon as the line changes. The block also watches the attention line for edges. On the edge polarity that software selects, it sets a pair of sticky flag bits, and those bits can raise an interrupt request. Register decode and the CPU itself live outside this block. The port registers arrive here as plain vectors.

There is no data stream here, so every pin is a plain level or strobe. No pin uses a valid/ready handshake and nothing applies back-pressure.

Top module: `sbp_port`

## Requirements
- R1: `in_byte` bit 0 is 1 when the data line is low, bit 2 is 1 when the clock line is low, and bit 7 is 1 when the attention line is low. Each bit follows its pin after two clock edges of synchronization.
- R2: `in_byte` bits 6:5 equal `dev_offset`, which is the device number minus 8. Bits 3 and 1 always read 0.
- R3: `in_byte` bit 4 equals `port_out` bit 4 with no delay.
- R4: `clk_pull` is 1 exactly when `port_out` bit 3 and `port_dir` bit 3 are both 1.
- R5: `data_pull` is 1 when `port_out` bit 1 and `port_dir` bit 1 are both 1, or when the acknowledge pull-down of R6 is active. The two pull-downs combine as a wired-AND on the line.
- R6: The acknowledge pull-down is active when "attention is low" (after synchronization) differs from the acknowledge enable. The enable is `port_out` bit 4 AND `port_dir` bit 4. The pull-down follows port changes at once and follows attention changes after the two-edge synchronizer.
- R7: With `edge_sel` = 0, a release (rising edge) of the attention line sets `flags` bits 7 and 1. The flags become visible three clock edges after the pin changes.
- R8: With `edge_sel` = 1, a falling edge of the attention line sets `flags` bits 7 and 1, with the same latency as R7.
- R9: An attention edge of the other polarity leaves `flags` unchanged. `flags` bits 6:2 and 0 always read 0.
- R10: `flags` stay set until `flag_clr` is sampled high. That strobe clears them on the next edge, but when a selected edge and the clear happen in the same cycle, the set wins.
- R11: `irq` equals `flags` bit 1 AND `irq_en`.
- R12: While `rst_n` is low, `flags` reset to 0 and the synchronized lines reset to released. So `in_byte` bits 7, 2 and 0 read 0 after reset until a line is pulled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| atn_in | input | 1 | Raw attention line, 1 = released |
| clk_in | input | 1 | Raw bus clock line, 1 = released |
| data_in | input | 1 | Raw data line, 1 = released |
| port_out | input | 8 | Port output register |
| port_dir | input | 8 | Port direction register, 1 = output |
| edge_sel | input | 1 | Attention edge select: 0 rising, 1 falling |
| dev_offset | input | 2 | Device number minus 8 |
| flag_clr | input | 1 | Clears the attention flags |
| irq_en | input | 1 | Interrupt enable for the attention flag |
| clk_pull | output | 1 | Pull the bus clock line low |
| data_pull | output | 1 | Pull the data line low (normal or acknowledge) |
| in_byte | output | 8 | Byte the CPU reads from the port |
| flags | output | 8 | Attention flag bits (7 and 1) |
| irq | output | 1 | Interrupt request |

## Verification
The pull-down logic is swept over all 64 settings of the output and direction bits 1, 3 and 4, under both attention levels. This separates a plain AND gating from the XOR acknowledge term, and a wrong bit pairing shows up as a mismatch in one corner of the sweep. The input byte is swept over all eight line patterns and all four device offsets, which catches swapped or non-inverted bit positions. Attention edges are applied in both polarities under both `edge_sel` values, which separates the selected edge from the ignored one. A further case lines up a clear with a new edge to confirm that the set wins, and `irq_en` is toggled to check the interrupt gating.

// File: rtl/sbp_pkg.sv
`timescale 1ns/1ps
package sbp_pkg;
  localparam int PORT_W  = 8;
  localparam int DEV_W   = 2;
  // input byte bit positions
  localparam int IN_DATA = 0;
  localparam int IN_CLK  = 2;
  localparam int IN_ACK  = 4;
  localparam int IN_DEV  = 5;
  localparam int IN_ATN  = 7;
  // output / direction register bit positions
  localparam int OUT_DATA = 1;
  localparam int OUT_CLK  = 3;
  localparam int OUT_ACK  = 4;
  // flag bit positions
  localparam int FLG_ANY = 7;
  localparam int FLG_ATN = 1;
  localparam int LINE_N  = 3;

  typedef struct packed {
    logic atn;
    logic clk;
    logic data;
  } bus_lines_t;
endpackage

// File: rtl/sbp_sync.sv
`timescale 1ns/1ps
module sbp_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int CHAIN_W = W * STAGES;
  logic [CHAIN_W-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= RST_VAL;
        else        chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[CHAIN_W-W-1:0], d};
      end
    end
  endgenerate

  assign q = chain[CHAIN_W-1 -: W];
endmodule

// File: rtl/sbp_drive.sv
`timescale 1ns/1ps
module sbp_drive (
  input  logic out_clk,
  input  logic dir_clk,
  input  logic out_data,
  input  logic dir_data,
  input  logic out_ack,
  input  logic dir_ack,
  input  logic atn_low,
  output logic clk_pull,
  output logic data_norm_pull,
  output logic ack_pull
);
  logic ack_en;

  always_comb begin
    ack_en         = out_ack & dir_ack;
    clk_pull       = out_clk & dir_clk;
    data_norm_pull = out_data & dir_data;
    ack_pull       = atn_low ^ ack_en;
  end
endmodule

// File: rtl/sbp_atn_edge.sv
`timescale 1ns/1ps
module sbp_atn_edge
  import sbp_pkg::*;
#(
  parameter int FW = PORT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          atn_line,
  input  logic          edge_sel,
  input  logic          flag_clr,
  input  logic          irq_en,
  output logic [FW-1:0] flags,
  output logic          irq
);
  localparam logic [FW-1:0] SET_MASK = FW'((1 << FLG_ANY) | (1 << FLG_ATN));

  logic atn_prev;
  logic rise, fall, hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) atn_prev <= 1'b1;
    else        atn_prev <= atn_line;
  end

  always_comb begin
    rise = atn_line & ~atn_prev;
    fall = ~atn_line & atn_prev;
    hit  = edge_sel ? fall : rise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flags <= '0;
    else if (hit)      flags <= flags | SET_MASK;
    else if (flag_clr) flags <= '0;
  end

  assign irq = flags[FLG_ATN] & irq_en;

  AST_FLAG_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    flags[FLG_ANY] == flags[FLG_ATN]); // R7
  AST_FLAG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[FLG_ATN]) |-> $past(hit)); // R8
  AST_UNUSED_FLAGS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (flags & ~SET_MASK) == '0); // R9
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    flags[FLG_ATN] && !flag_clr |=> flags[FLG_ATN]); // R10
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flags[FLG_ATN]); // R10
  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flags[FLG_ATN]); // R11
endmodule

// File: rtl/sbp_port.sv
`timescale 1ns/1ps
module sbp_port
  import sbp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              atn_in,
  input  logic              clk_in,
  input  logic              data_in,
  input  logic [PORT_W-1:0] port_out,
  input  logic [PORT_W-1:0] port_dir,
  input  logic              edge_sel,
  input  logic [DEV_W-1:0]  dev_offset,
  input  logic              flag_clr,
  input  logic              irq_en,
  output logic              clk_pull,
  output logic              data_pull,
  output logic [PORT_W-1:0] in_byte,
  output logic [PORT_W-1:0] flags,
  output logic              irq
);
  bus_lines_t raw_lines, sync_lines;
  logic data_norm_pull, ack_pull;
  logic unused_port_bits;

  assign raw_lines = '{atn: atn_in, clk: clk_in, data: data_in};

  sbp_sync #(
    .W(LINE_N),
    .STAGES(SYNC_STAGES),
    .RST_VAL('1)
  ) sync_i (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (raw_lines),
    .q    (sync_lines)
  );

  sbp_drive drive_i (
    .out_clk       (port_out[OUT_CLK]),
    .dir_clk       (port_dir[OUT_CLK]),
    .out_data      (port_out[OUT_DATA]),
    .dir_data      (port_dir[OUT_DATA]),
    .out_ack       (port_out[OUT_ACK]),
    .dir_ack       (port_dir[OUT_ACK]),
    .atn_low       (~sync_lines.atn),
    .clk_pull      (clk_pull),
    .data_norm_pull(data_norm_pull),
    .ack_pull      (ack_pull)
  );

  // both pull-downs share one open-collector line
  assign data_pull = data_norm_pull | ack_pull;

  always_comb begin
    in_byte                      = '0;
    in_byte[IN_DATA]             = ~sync_lines.data;
    in_byte[IN_CLK]              = ~sync_lines.clk;
    in_byte[IN_ACK]              = port_out[OUT_ACK];
    in_byte[IN_DEV +: DEV_W]     = dev_offset;
    in_byte[IN_ATN]              = ~sync_lines.atn;
  end

  sbp_atn_edge #(.FW(PORT_W)) edge_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .atn_line(sync_lines.atn),
    .edge_sel(edge_sel),
    .flag_clr(flag_clr),
    .irq_en  (irq_en),
    .flags   (flags),
    .irq     (irq)
  );

  assign unused_port_bits = ^{port_out[7:5], port_out[2], port_out[0],
                              port_dir[7:5], port_dir[2], port_dir[0]};

  AST_ACK_REACHES_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    ack_pull |-> data_pull); // R5
  AST_NORMAL_REACHES_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    data_norm_pull |-> data_pull); // R5
  AST_ATN_BIT_TRACKS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    in_byte[IN_ATN] == (ack_pull ^ (port_out[OUT_ACK] & port_dir[OUT_ACK]))); // R6
endmodule

// File: tb/sbp_port_tb.sv
`timescale 1ns/1ps
module sbp_port_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic atn_in = 1'b1, clk_in = 1'b1, data_in = 1'b1;
  logic [7:0] port_out = '0, port_dir = '0;
  logic edge_sel = 1'b0;
  logic [1:0] dev_offset = '0;
  logic flag_clr = 1'b0, irq_en = 1'b0;
  logic clk_pull, data_pull, irq;
  logic [7:0] in_byte, flags;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sbp_port dut_i (
    .clk(clk), .rst_n(rst_n), .atn_in(atn_in), .clk_in(clk_in), .data_in(data_in),
    .port_out(port_out), .port_dir(port_dir), .edge_sel(edge_sel),
    .dev_offset(dev_offset), .flag_clr(flag_clr), .irq_en(irq_en),
    .clk_pull(clk_pull), .data_pull(data_pull), .in_byte(in_byte),
    .flags(flags), .irq(irq)
  );

  task automatic check(string req, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic settle(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [7:0] exp_byte(logic a, logic c, logic d,
                                          logic [1:0] dv, logic o4);
    return {~a, dv, o4, 1'b0, ~c, 1'b0, ~d};
  endfunction

  task automatic clear_flags();
    flag_clr = 1'b1;
    settle(1);
    flag_clr = 1'b0;
  endtask

  // one attention edge, flags checked three edges after the pin moves
  task automatic edge_case(logic sel, logic new_level);
    logic expect_set;
    edge_sel = sel;
    clear_flags();
    atn_in = new_level;
    settle(2);
    check("R9 no early set", flags, 8'h00);
    settle(1);
    expect_set = sel ? ~new_level : new_level;
    if (sel) check("R8 falling select", flags, expect_set ? 8'h82 : 8'h00);
    else     check("R7 rising select", flags, expect_set ? 8'h82 : 8'h00);
    if (!expect_set) check("R9 other edge ignored", flags, 8'h00);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    settle(2);
    // R12 reset state
    check("R12 flags in reset", flags, 8'h00);
    check("R12 in_byte in reset", in_byte, 8'h00);
    check("R12 irq in reset", {7'b0, irq}, 8'h00);
    rst_n = 1'b1;
    settle(1);

    // R1 R2 R3: input byte over all line patterns and device offsets
    for (int p = 0; p < 8; p++) begin
      for (int dv = 0; dv < 4; dv++) begin
        atn_in = p[2]; clk_in = p[1]; data_in = p[0];
        dev_offset = dv[1:0];
        port_out = {3'b0, dv[0], 4'b0};
        settle(2);
        check("R1 R2 R3 input byte", in_byte,
              exp_byte(p[2], p[1], p[0], dv[1:0], dv[0]));
      end
    end
    atn_in = 1'b1; clk_in = 1'b1; data_in = 1'b1;
    settle(2);

    // R4 R5 R6: pull-down sweep over bits 1,3,4 of out and dir, both ATN levels
    for (int a = 0; a < 2; a++) begin
      atn_in = a[0];
      settle(2);
      for (int o = 0; o < 8; o++) begin
        for (int d = 0; d < 8; d++) begin
          logic ack_en, ack, exp_clk, exp_data;
          port_out = {3'b101, o[2], o[1], 1'b1, o[0], 1'b1};
          port_dir = {3'b110, d[2], d[1], 1'b0, d[0], 1'b0};
          #1;
          ack_en   = o[2] & d[2];
          ack      = (~a[0]) ^ ack_en;
          exp_clk  = o[1] & d[1];
          exp_data = (o[0] & d[0]) | ack;
          check("R4 clk pull", {7'b0, clk_pull}, {7'b0, exp_clk});
          check("R5 R6 data pull", {7'b0, data_pull}, {7'b0, exp_data});
          check("R3 ack readback", {7'b0, in_byte[4]}, {7'b0, o[2]});
          @(negedge clk);
        end
      end
    end
    port_out = '0; port_dir = '0;
    atn_in = 1'b1;
    settle(2);

    // R6: ack pull follows ATN after two edges
    port_out = 8'h10; port_dir = 8'h10;
    #1 check("R6 ack enabled, atn released", {7'b0, data_pull}, 8'h01);
    atn_in = 1'b0;
    settle(1);
    check("R6 still one edge in", {7'b0, data_pull}, 8'h01);
    settle(1);
    check("R6 atn low matches enable", {7'b0, data_pull}, 8'h00);
    port_out = '0; port_dir = '0;
    atn_in = 1'b1;
    settle(3);

    // R7 R8 R9: both edges under both selections
    edge_case(1'b0, 1'b0);
    edge_case(1'b0, 1'b1);
    edge_case(1'b1, 1'b0);
    edge_case(1'b1, 1'b1);

    // R10: sticky, then cleared
    edge_sel = 1'b1;
    clear_flags();
    atn_in = 1'b0;
    settle(3);
    check("R10 set", flags, 8'h82);
    settle(4);
    check("R10 sticky", flags, 8'h82);
    // R11: irq gating
    irq_en = 1'b0;
    #1 check("R11 irq masked", {7'b0, irq}, 8'h00);
    irq_en = 1'b1;
    #1 check("R11 irq enabled", {7'b0, irq}, 8'h01);
    clear_flags();
    check("R10 cleared", flags, 8'h00);
    check("R11 irq after clear", {7'b0, irq}, 8'h00);

    // R10: clear held across a selected edge, set wins
    flag_clr = 1'b1;
    atn_in = 1'b1;
    settle(3);
    atn_in = 1'b0;
    settle(3);
    check("R10 set wins over clear", flags, 8'h82);
    settle(1);
    check("R10 clear after collision", flags, 8'h00);
    flag_clr = 1'b0;
    irq_en = 1'b0;

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule